// File: doc/BRIEF.md
# Two-Stage Refreshable Watchdog Timer

This block is a watchdog that software maintains through a small 32-bit register port. It watches a free-running 64-bit system counter and compares it with a stored 64-bit deadline. While the watchdog is enabled, the first deadline that passes without a refresh raises a first-stage flag, which drives an interrupt line. The deadline is then pushed out again by a programmable 48-bit interval. If that second deadline also passes, a second-stage flag is raised. A system reset controller outside the block is expected to act on the second-stage flag.

Software keeps the watchdog quiet by refreshing it. A refresh clears both flags and moves the deadline to the current counter value plus the interval. Four kinds of write cause a refresh: a write to the control word, a write to either half of the interval, and a write to the dedicated refresh word. Writing the deadline words directly stores the new value and does not refresh. Register reads are combinational and show the current contents.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the enable bit, both stage flags, the 48-bit interval and the 64-bit deadline are all zero, and both outputs are low. The identification word (index 6) reads the constant 32'h5744_0A01.
- R2: A write to the control word (index 0) stores only write-data bit 0 as the enable bit, clears both stage flags, and sets the deadline to the counter value plus the interval.
- R3: A write to the interval low word (index 2) replaces interval bits 31:0. A write to the interval high word (index 3) replaces interval bits 47:32 with write-data bits 15:0 and ignores the rest. Either write, in any order, clears both flags and refreshes the deadline using the interval value just written.
- R4: A write to the refresh word (index 1) clears both flags and sets the deadline to the counter value plus the zero-extended interval.
- R5: Writes to the deadline low word (index 4) and high word (index 5) store that 32-bit half directly. They leave the flags and the enable bit untouched. If such a write falls in the same cycle as a first timeout, the written half replaces that half of the reloaded deadline.
- R6: While enabled, with the first-stage flag clear and no refreshing write in the cycle, a counter value at or above the deadline sets the first-stage flag on the next clock edge and reloads the deadline to the counter value plus the interval.
- R7: While enabled, with the first-stage flag already set, a counter value at or above the deadline sets the second-stage flag. The second-stage flag stays set until a refreshing write clears it.
- R8: While the enable bit is zero, no counter value changes either flag.
- R9: `stage0_irq` follows the first-stage flag, both rising and falling. `stage1_out` follows the second-stage flag.
- R10: Reads return: at index 0, enable in bit 0, first stage in bit 1, second stage in bit 2, and zeros above; at index 1, zero; at index 2, interval bits 31:0; at index 3, interval bits 47:32 zero-extended; at index 4, deadline bits 31:0; at index 5, deadline bits 63:32.
- R11: Writes to the identification word (index 6) or to the unmapped index 7 change no register and no output. Index 7 reads zero.
- R12: A refreshing write in the same cycle as a timeout takes precedence. The flags end clear and the deadline is the counter value plus the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| sys_count | input | 64 | Free-running system counter |
| stage0_irq | output | 1 | First-stage interrupt, equal to the first-stage flag |
| stage1_out | output | 1 | Second-stage signal, equal to the second-stage flag |

## Verification
Two functions can land in the same clock edge: a refreshing write and a counter value that has just reached the deadline. Both try to update the flags and the deadline. The bench provokes this on purpose. It parks the counter exactly on the deadline and issues a refresh-word write and then a control write in that cycle. It also lets the constrained-random phase hit the case often, using small intervals and a slowly advancing counter. Each outcome is judged against a bench model in which the write wins, and the first-stage flag must still rise on the following idle cycle. The same model decides the weaker overlap between a deadline-word write and a first timeout.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int OFS_W  = 48,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5744_0A01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  sys_count,
  output logic              stage0_irq,
  output logic              stage1_out
);
  localparam int OFS_HI_W = OFS_W - DATA_W;
  localparam int CMP_HI_W = CNT_W - DATA_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OLO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OHI  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(6);

  logic             en_q, st0_q, st1_q;
  logic [OFS_W-1:0] ofs_q, ofs_nx;
  logic [CNT_W-1:0] cmp_q, cmp_nx, reload;

  wire sel_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire sel_kick = bus_wr && (bus_addr == A_KICK);
  wire sel_olo  = bus_wr && (bus_addr == A_OLO);
  wire sel_ohi  = bus_wr && (bus_addr == A_OHI);
  wire sel_clo  = bus_wr && (bus_addr == A_CLO);
  wire sel_chi  = bus_wr && (bus_addr == A_CHI);
  wire clr_wr   = sel_ctrl | sel_kick | sel_olo | sel_ohi;
  wire expired  = en_q && (sys_count >= cmp_q);

  always_comb begin
    ofs_nx = ofs_q;
    if (sel_olo) ofs_nx[DATA_W-1:0] = bus_wdata;
    if (sel_ohi) ofs_nx[OFS_W-1:DATA_W] = bus_wdata[OFS_HI_W-1:0];
  end

  assign reload = sys_count + CNT_W'(ofs_nx);

  always_comb begin
    cmp_nx = cmp_q;
    if (clr_wr) begin
      cmp_nx = reload;
    end else begin
      if (expired && !st0_q) cmp_nx = reload;
      if (sel_clo) cmp_nx[DATA_W-1:0] = bus_wdata;
      if (sel_chi) cmp_nx[CNT_W-1:DATA_W] = bus_wdata[CMP_HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      st0_q <= 1'b0;
      st1_q <= 1'b0;
      ofs_q <= '0;
      cmp_q <= '0;
    end else begin
      if (sel_ctrl) en_q <= bus_wdata[0];
      ofs_q <= ofs_nx;
      cmp_q <= cmp_nx;
      if (clr_wr) begin
        st0_q <= 1'b0;
        st1_q <= 1'b0;
      end else if (expired) begin
        if (!st0_q) st0_q <= 1'b1;
        else        st1_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'({st1_q, st0_q, en_q});
      A_OLO:   bus_rdata = ofs_q[DATA_W-1:0];
      A_OHI:   bus_rdata = DATA_W'(ofs_q[OFS_W-1:DATA_W]);
      A_CLO:   bus_rdata = cmp_q[DATA_W-1:0];
      A_CHI:   bus_rdata = DATA_W'(cmp_q[CNT_W-1:DATA_W]);
      A_ID:    bus_rdata = ID_VALUE;
      default: bus_rdata = '0;
    endcase
  end

  assign stage0_irq = st0_q;
  assign stage1_out = st1_q;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  sys_count,
  input logic              en_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic              stage0_irq,
  input logic              stage1_out
);
  wire refresh_wr = bus_wr && (bus_addr < ADDR_W'(4));
  wire cmp_wr     = bus_wr && ((bus_addr == ADDR_W'(4)) || (bus_addr == ADDR_W'(5)));

  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_wr |=> (!stage0_irq && !stage1_out)); // R12

  AST_STAGE1_AFTER_STAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage1_out) |-> $past(stage0_irq)); // R7

  AST_STAGE1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stage1_out && !refresh_wr) |=> stage1_out); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !refresh_wr) |=> ($stable(stage0_irq) && $stable(stage1_out))); // R8

  AST_CMP_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && stage0_irq) |=> stage0_irq); // R5

  AST_FIRST_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !stage0_irq && !bus_wr && (sys_count >= cmp_q)) |=> stage0_irq); // R6
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .sys_count(sys_count), .en_q(en_q), .cmp_q(cmp_q),
  .stage0_irq(stage0_irq), .stage1_out(stage1_out)
);

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [63:0] sys_count = 64'd0;
  logic        stage0_irq, stage1_out;

  always #5 clk = ~clk;

  wdog_two_stage uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_count(sys_count),
    .stage0_irq(stage0_irq), .stage1_out(stage1_out)
  );

  logic        m_en, m_st0, m_st1;
  logic [47:0] m_ofs;
  logic [63:0] m_cmp;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [63:0] cnt = 64'd0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, m_st1, m_st0, m_en};
      3'd2: return m_ofs[31:0];
      3'd3: return {16'd0, m_ofs[47:32]};
      3'd4: return m_cmp[31:0];
      3'd5: return m_cmp[63:32];
      3'd6: return 32'h5744_0A01;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input bit wr, input logic [2:0] a, input logic [31:0] d,
                      input logic [63:0] c, input string tag, input bit sweep);
    logic        n_en, n_st0, n_st1, clr, exp_hit;
    logic [47:0] n_ofs;
    logic [63:0] n_cmp;
    bus_wr = 1'b0;
    if (sweep) begin
      for (int i = 0; i < 8; i++) begin
        bus_addr = 3'(i);
        #1;
        chk($sformatf("%s read idx %0d", tag, i), 64'(bus_rdata), 64'(model_read(3'(i))));
      end
    end else #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; sys_count = c;
    clr = wr && (a < 3'd4);
    n_en = (wr && a == 3'd0) ? d[0] : m_en;
    n_ofs = m_ofs;
    if (wr && a == 3'd2) n_ofs[31:0] = d;
    if (wr && a == 3'd3) n_ofs[47:32] = d[15:0];
    n_st0 = m_st0; n_st1 = m_st1; n_cmp = m_cmp;
    exp_hit = m_en && (c >= m_cmp);
    if (clr) begin
      n_st0 = 1'b0; n_st1 = 1'b0; n_cmp = c + {16'd0, n_ofs};
    end else begin
      if (exp_hit) begin
        if (!m_st0) begin n_st0 = 1'b1; n_cmp = c + {16'd0, m_ofs}; end
        else n_st1 = 1'b1;
      end
      if (wr && a == 3'd4) n_cmp[31:0] = d;
      if (wr && a == 3'd5) n_cmp[63:32] = d;
    end
    @(posedge clk);
    m_en = n_en; m_st0 = n_st0; m_st1 = n_st1; m_ofs = n_ofs; m_cmp = n_cmp;
    #1;
    chk({tag, " stage0_irq"}, 64'(stage0_irq), 64'(m_st0));
    chk({tag, " stage1_out"}, 64'(stage1_out), 64'(m_st1));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog (R1..): actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    m_en = 0; m_st0 = 0; m_st1 = 0; m_ofs = '0; m_cmp = '0;
    repeat (3) @(posedge clk);
    chk("R1 reset stage0_irq", 64'(stage0_irq), 64'd0);
    chk("R1 reset stage1_out", 64'(stage1_out), 64'd0);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    step(0, 0, 0, 64'd100, "R1", 1);
    // R3 low half then R2 control with junk upper bits
    step(1, 3'd2, 32'd10, 64'd100, "R3", 0);
    step(1, 3'd0, 32'hFFFF_FFFF, 64'd100, "R2", 1);
    step(0, 0, 0, 64'd105, "R2", 1);
    step(0, 0, 0, 64'd109, "R6", 0);
    step(0, 0, 0, 64'd110, "R6", 1);
    step(0, 0, 0, 64'd119, "R9", 0);
    step(0, 0, 0, 64'd125, "R7", 1);
    step(0, 0, 0, 64'd200, "R7", 0);
    step(1, 3'd4, 32'd5000, 64'd200, "R5", 1);
    step(1, 3'd5, 32'd0, 64'd300, "R5", 1);
    step(1, 3'd1, 32'hDEAD_BEEF, 64'd300, "R4", 1);
    step(0, 0, 0, 64'd305, "R9", 0);
    step(1, 3'd3, 32'd1, 64'd300, "R3", 1);
    step(1, 3'd3, 32'hABCD_0002, 64'd300, "R3", 1);
    step(1, 3'd3, 32'd0, 64'd300, "R10", 1);
    step(1, 3'd7, 32'hFFFF_FFFF, 64'd300, "R11", 1);
    step(1, 3'd6, 32'h0000_0000, 64'd300, "R11", 1);
    step(0, 0, 0, 64'd300, "R11", 1);
    step(1, 3'd0, 32'd0, 64'd400, "R8", 0);
    step(0, 0, 0, 64'hFFFF_FFFF_0000_0000, "R8", 1);
    step(1, 3'd2, 32'd5, 64'd1000, "R12", 0);
    step(1, 3'd0, 32'd1, 64'd1000, "R12", 1);
    step(1, 3'd1, 32'd0, 64'd1005, "R12", 1);
    step(1, 3'd0, 32'd1, 64'd1010, "R12", 1);
    step(0, 0, 0, 64'd1015, "R6", 1);
    cnt = 64'd1015;
    for (int n = 0; n < 3000; n++) begin
      bit          wr;
      logic [2:0]  a;
      logic [31:0] d;
      cnt = cnt + 64'($urandom_range(0, 6));
      if ($urandom_range(0, 199) == 0) cnt = cnt + 64'($urandom);
      wr = ($urandom_range(0, 3) == 0);
      a = 3'($urandom_range(0, 7));
      case (a)
        3'd0: d = $urandom | 32'(($urandom_range(0, 4) != 0) ? 1 : 0);
        3'd2: d = 32'($urandom_range(0, 30));
        3'd3: d = ($urandom_range(0, 7) == 0) ? $urandom : 32'd0;
        3'd4: d = cnt[31:0] + 32'($urandom_range(0, 20));
        3'd5: d = cnt[63:32];
        default: d = $urandom;
      endcase
      step(wr, a, d, cnt, "R6 R7 R12 random", ($urandom_range(0, 7) == 0));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule